// File: doc/BRIEF.md
# Multi-Mode 16-Bit Down-Counting Timer

This block is a 16-bit down counter with two 16-bit companion registers, A and B. A small register bus programs it. Software picks one of three modes with a control field.

In PWM mode the counter steps down on every cycle where the `tick` strobe is high. Each time it passes zero it reloads from A or B in turn, so the ON and OFF times of the waveform on pin A are set independently. In event-counter mode the counter steps down on a chosen edge of pin A, and pin B becomes a separate rising-edge event input. In capture mode the counter runs freely on `tick`, and edges on pin A or pin B snapshot the counter into register A or register B.

Every event sets one of two sticky pending bits. Software clears a pending bit by writing a 1 to it. Each pending bit is gated by its enable bit to form an interrupt request. Both pins pass through a two-flop synchronizer before edge detection.

Top module: `tri_mode_timer`

## Requirements
- R1: After reset the counter, register A, register B, the control word and both pending bits read 0, both IRQs are low, and `pin_a_out` and `pin_a_oe` are low.
- R2: A bus write stores `wdata` at the addressed location, and `rdata` returns it combinationally. The address map is 0 counter, 1 register A, 2 register B, 3 control, 4 pending. In the control word, bits [2:0] hold the mode, bit 3 enables the output toggle, bit 4 is enable A and bit 5 is enable B. In the pending word, bit 0 is pending A and bit 1 is pending B.
- R3: In PWM mode (mode 1) the counter decreases by one on each clock where `tick` is high, and it holds its value while `tick` is low.
- R4: In PWM mode, when a ticked cycle finds the counter at 0, the counter reloads instead of decrementing. The first reload after any control write takes register A, and later reloads alternate B, A, B and so on.
- R5: In PWM mode with the toggle bit set, every reload inverts `pin_a_out`, and a control write returns it to 0. `pin_a_oe` is high only in PWM mode.
- R6: A reload from register A sets pending A, and a reload from register B sets pending B.
- R7: `irq_a` is high exactly when pending A and enable A are both set, and `irq_b` is high exactly when pending B and enable B are both set.
- R8: In event mode the counter steps only on synchronized edges of pin A: rising edges in mode 2 and falling edges in mode 3. `tick` has no effect. A step taken at 0 reloads from register A and sets pending A.
- R9: In event mode a rising edge on pin B sets pending B, and the counter does not change.
- R10: In capture mode (mode 4) the counter decrements on `tick` and wraps from 0 to 0xFFFF. A rising edge on pin A copies the counter into register A and sets pending A. A rising edge on pin B does the same with register B and pending B.
- R11: Pending bits stay set until software writes a 1 to them. If a set and a clear fall in the same cycle, the set wins.
- R12: A pin held at one level for many cycles produces exactly one event per edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tick | input | 1 | Fixed-rate count strobe |
| wr_en | input | 1 | Register write strobe |
| addr | input | 3 | Register address |
| wdata | input | 16 | Write data |
| rdata | output | 16 | Read data for `addr` |
| pin_a_in | input | 1 | Pin A input (event or capture source) |
| pin_b_in | input | 1 | Pin B input |
| pin_a_out | output | 1 | PWM waveform |
| pin_a_oe | output | 1 | Pin A output enable |
| irq_a | output | 1 | Interrupt request, channel A |
| irq_b | output | 1 | Interrupt request, channel B |

## Verification
Two functions can meet in one cycle: a capture edge that sets a pending bit, and a software write of 1 that clears the same bit. The bench raises pin B and counts the synchronizer latency so that the pending write lands on exactly the clock where the edge takes effect. It then expects pending B to read 1 and register B to hold the new counter value. A later stand-alone clear must still empty the bit, which shows that the clear path itself works.

// File: rtl/tmr_pkg.sv
package tmr_pkg;

    localparam int CTRL_W = 6;
    localparam int PEND_W = 2;

    typedef enum logic [2:0] {
        MODE_IDLE     = 3'd0,
        MODE_PWM      = 3'd1,
        MODE_EVT_RISE = 3'd2,
        MODE_EVT_FALL = 3'd3,
        MODE_CAPT     = 3'd4
    } tmr_mode_e;

    typedef enum logic [2:0] {
        ADR_CNT  = 3'd0,
        ADR_RA   = 3'd1,
        ADR_RB   = 3'd2,
        ADR_CTRL = 3'd3,
        ADR_PEND = 3'd4
    } tmr_addr_e;

    typedef struct packed {
        logic       en_b;
        logic       en_a;
        logic       tog_en;
        logic [2:0] mode;
    } tmr_ctrl_t;

    function automatic tmr_mode_e decode_mode(input logic [2:0] f);
        case (f)
            3'd1:    return MODE_PWM;
            3'd2:    return MODE_EVT_RISE;
            3'd3:    return MODE_EVT_FALL;
            3'd4:    return MODE_CAPT;
            default: return MODE_IDLE;
        endcase
    endfunction

endpackage

// File: rtl/tmr_edge_sync.sv
module tmr_edge_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic pin,
    input  logic fall_sel,
    output logic evt
);
    localparam int CW = STAGES + 1;

    typedef struct packed {
        logic [CW-1:0] chain;
    } sync_st_t;

    sync_st_t st_d, st_q;
    logic     lvl_now, lvl_old;

    always_comb begin
        st_d       = st_q;
        st_d.chain = {st_q.chain[CW-2:0], pin};
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign lvl_now = st_q.chain[STAGES-1];
    assign lvl_old = st_q.chain[STAGES];
    assign evt     = fall_sel ? (lvl_old & ~lvl_now) : (lvl_now & ~lvl_old);

    AST_ONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        evt |=> (!evt || (fall_sel != $past(fall_sel)))); // R12

endmodule

// File: rtl/tmr_bus.sv
module tmr_bus
    import tmr_pkg::*;
#(
    parameter int WIDTH = 16
) (
    input  logic             wr_en,
    input  logic [2:0]       addr,
    input  logic [WIDTH-1:0] cnt,
    input  logic [WIDTH-1:0] reg_a,
    input  logic [WIDTH-1:0] reg_b,
    input  tmr_ctrl_t        ctrl,
    input  logic [PEND_W-1:0] pend,
    output logic             wr_cnt,
    output logic             wr_ra,
    output logic             wr_rb,
    output logic             wr_ctrl,
    output logic             wr_pend,
    output logic [WIDTH-1:0] rdata
);
    localparam int CPAD = WIDTH - CTRL_W;
    localparam int PPAD = WIDTH - PEND_W;

    tmr_addr_e sel;
    assign sel = tmr_addr_e'(addr);

    always_comb begin
        wr_cnt  = 1'b0;
        wr_ra   = 1'b0;
        wr_rb   = 1'b0;
        wr_ctrl = 1'b0;
        wr_pend = 1'b0;
        rdata   = '0;
        case (sel)
            ADR_CNT: begin
                wr_cnt = wr_en;
                rdata  = cnt;
            end
            ADR_RA: begin
                wr_ra = wr_en;
                rdata = reg_a;
            end
            ADR_RB: begin
                wr_rb = wr_en;
                rdata = reg_b;
            end
            ADR_CTRL: begin
                wr_ctrl = wr_en;
                rdata   = {{CPAD{1'b0}}, ctrl};
            end
            ADR_PEND: begin
                wr_pend = wr_en;
                rdata   = {{PPAD{1'b0}}, pend};
            end
            default: rdata = '0;
        endcase
    end

endmodule

// File: rtl/tmr_core.sv
module tmr_core
    import tmr_pkg::*;
#(
    parameter int WIDTH = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick,
    input  logic              evt_a,
    input  logic              evt_b,
    input  logic              wr_cnt,
    input  logic              wr_ra,
    input  logic              wr_rb,
    input  logic              wr_ctrl,
    input  logic              wr_pend,
    input  logic [WIDTH-1:0]  wdata,
    output logic [WIDTH-1:0]  cnt,
    output logic [WIDTH-1:0]  reg_a,
    output logic [WIDTH-1:0]  reg_b,
    output tmr_ctrl_t         ctrl,
    output logic [PEND_W-1:0] pend,
    output logic              pwm_out
);
    typedef struct packed {
        logic [WIDTH-1:0]  cnt;
        logic [WIDTH-1:0]  ra;
        logic [WIDTH-1:0]  rb;
        tmr_ctrl_t         ctrl;
        logic [PEND_W-1:0] pend;
        logic              sel_b;
        logic              pwm;
    } core_st_t;

    core_st_t  st_d, st_q;
    tmr_mode_e mode;
    logic      set_a, set_b;
    logic      at_zero;
    logic      cap_a, cap_b;

    assign mode    = decode_mode(st_q.ctrl.mode);
    assign at_zero = (st_q.cnt == '0);

    always_comb begin
        st_d  = st_q;
        set_a = 1'b0;
        set_b = 1'b0;
        cap_a = 1'b0;
        cap_b = 1'b0;

        case (mode)
            MODE_PWM: begin
                if (tick) begin
                    if (at_zero) begin
                        st_d.cnt   = st_q.sel_b ? st_q.rb : st_q.ra;
                        set_a      = ~st_q.sel_b;
                        set_b      = st_q.sel_b;
                        st_d.sel_b = ~st_q.sel_b;
                        if (st_q.ctrl.tog_en) st_d.pwm = ~st_q.pwm;
                    end else begin
                        st_d.cnt = st_q.cnt - 1'b1;
                    end
                end
            end
            MODE_EVT_RISE, MODE_EVT_FALL: begin
                if (evt_a) begin
                    if (at_zero) begin
                        st_d.cnt = st_q.ra;
                        set_a    = 1'b1;
                    end else begin
                        st_d.cnt = st_q.cnt - 1'b1;
                    end
                end
                set_b = evt_b;
            end
            MODE_CAPT: begin
                if (tick) st_d.cnt = st_q.cnt - 1'b1;
                cap_a = evt_a;
                cap_b = evt_b;
                set_a = evt_a;
                set_b = evt_b;
                if (evt_a) st_d.ra = st_q.cnt;
                if (evt_b) st_d.rb = st_q.cnt;
            end
            default: st_d.cnt = st_q.cnt;
        endcase

        // software access; a capture in the same cycle takes precedence
        if (wr_cnt)          st_d.cnt = wdata;
        if (wr_ra && !cap_a) st_d.ra  = wdata;
        if (wr_rb && !cap_b) st_d.rb  = wdata;
        if (wr_ctrl) begin
            st_d.ctrl  = tmr_ctrl_t'(wdata[CTRL_W-1:0]);
            st_d.sel_b = 1'b0;
            st_d.pwm   = 1'b0;
        end
        if (wr_pend) st_d.pend = st_d.pend & ~wdata[PEND_W-1:0];
        st_d.pend = st_d.pend | {set_b, set_a};
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign cnt     = st_q.cnt;
    assign reg_a   = st_q.ra;
    assign reg_b   = st_q.rb;
    assign ctrl    = st_q.ctrl;
    assign pend    = st_q.pend;
    assign pwm_out = st_q.pwm;

    AST_HOLD_NO_TICK: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == MODE_PWM && !tick && !wr_cnt) |=> $stable(st_q.cnt)); // R3

    AST_RELOAD_SRC: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == MODE_PWM && tick && at_zero && !wr_cnt)
        |=> st_q.cnt == ($past(st_q.sel_b) ? $past(st_q.rb) : $past(st_q.ra))); // R4

    AST_TOGGLE: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == MODE_PWM && tick && at_zero && st_q.ctrl.tog_en && !wr_ctrl)
        |=> st_q.pwm != $past(st_q.pwm)); // R5

    AST_CAPTURE_A: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == MODE_CAPT && evt_a) |=> (st_q.ra == $past(st_q.cnt) && st_q.pend[0])); // R10

    AST_PEND_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.pend[1] && !(wr_pend && wdata[1])) |=> st_q.pend[1]); // R11

endmodule

// File: rtl/tri_mode_timer.sv
module tri_mode_timer
    import tmr_pkg::*;
#(
    parameter int WIDTH       = 16,
    parameter int SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick,
    input  logic             wr_en,
    input  logic [2:0]       addr,
    input  logic [WIDTH-1:0] wdata,
    output logic [WIDTH-1:0] rdata,
    input  logic             pin_a_in,
    input  logic             pin_b_in,
    output logic             pin_a_out,
    output logic             pin_a_oe,
    output logic             irq_a,
    output logic             irq_b
);
    localparam int NPINS = 2;

    logic [WIDTH-1:0]  cnt, reg_a, reg_b;
    tmr_ctrl_t         ctrl;
    logic [PEND_W-1:0] pend;
    logic              wr_cnt, wr_ra, wr_rb, wr_ctrl, wr_pend;
    logic [NPINS-1:0]  pins, fall_sel, evt;
    tmr_mode_e         mode;
    logic              pwm_out;

    assign mode     = decode_mode(ctrl.mode);
    assign pins     = {pin_b_in, pin_a_in};
    assign fall_sel = {1'b0, (mode == MODE_EVT_FALL)};

    for (genvar p = 0; p < NPINS; p++) begin : g_pin
        tmr_edge_sync #(.STAGES(SYNC_STAGES)) u_sync (
            .clk      (clk),
            .rst_n    (rst_n),
            .pin      (pins[p]),
            .fall_sel (fall_sel[p]),
            .evt      (evt[p])
        );
    end

    tmr_bus #(.WIDTH(WIDTH)) u_bus (
        .wr_en   (wr_en),
        .addr    (addr),
        .cnt     (cnt),
        .reg_a   (reg_a),
        .reg_b   (reg_b),
        .ctrl    (ctrl),
        .pend    (pend),
        .wr_cnt  (wr_cnt),
        .wr_ra   (wr_ra),
        .wr_rb   (wr_rb),
        .wr_ctrl (wr_ctrl),
        .wr_pend (wr_pend),
        .rdata   (rdata)
    );

    tmr_core #(.WIDTH(WIDTH)) u_core (
        .clk     (clk),
        .rst_n   (rst_n),
        .tick    (tick),
        .evt_a   (evt[0]),
        .evt_b   (evt[1]),
        .wr_cnt  (wr_cnt),
        .wr_ra   (wr_ra),
        .wr_rb   (wr_rb),
        .wr_ctrl (wr_ctrl),
        .wr_pend (wr_pend),
        .wdata   (wdata),
        .cnt     (cnt),
        .reg_a   (reg_a),
        .reg_b   (reg_b),
        .ctrl    (ctrl),
        .pend    (pend),
        .pwm_out (pwm_out)
    );

    assign pin_a_oe  = (mode == MODE_PWM);
    assign pin_a_out = pwm_out & pin_a_oe;
    assign irq_a     = pend[0] & ctrl.en_a;
    assign irq_b     = pend[1] & ctrl.en_b;

    AST_IRQ_B_GATED: assert property (@(posedge clk) disable iff (!rst_n)
        (!pend[1] || !ctrl.en_b) |-> !irq_b); // R7

endmodule

// File: tb/sim_tri_mode_timer.sv
`timescale 1ns/1ps
module sim_tri_mode_timer;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        tick = 1'b0;
    logic        wr_en = 1'b0;
    logic [2:0]  addr = '0;
    logic [15:0] wdata = '0;
    logic [15:0] rdata;
    logic        pin_a_in = 1'b0;
    logic        pin_b_in = 1'b0;
    logic        pin_a_out, pin_a_oe, irq_a, irq_b;

    int n_chk = 0;
    int n_bad = 0;
    bit done  = 0;

    always #2.5 clk = ~clk;

    tri_mode_timer u0 (
        .clk(clk), .rst_n(rst_n), .tick(tick), .wr_en(wr_en), .addr(addr),
        .wdata(wdata), .rdata(rdata), .pin_a_in(pin_a_in), .pin_b_in(pin_b_in),
        .pin_a_out(pin_a_out), .pin_a_oe(pin_a_oe), .irq_a(irq_a), .irq_b(irq_b)
    );

    task automatic check(input string tag, input logic [31:0] got, input logic [31:0] exp);
        n_chk++;
        if (got !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h", tag, got, exp);
        end
    endtask

    // all tasks start and end on a falling edge
    task automatic bus_wr(input logic [2:0] a, input logic [15:0] d);
        addr = a; wdata = d; wr_en = 1'b1;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd(input logic [2:0] a, output logic [15:0] d);
        addr = a; #0.1; d = rdata;
    endtask

    task automatic ticks(input int n);
        tick = 1'b1;
        repeat (n) @(negedge clk);
        tick = 1'b0;
    endtask

    task automatic pulse_a();
        pin_a_in = 1'b1; repeat (4) @(negedge clk);
        pin_a_in = 1'b0; repeat (4) @(negedge clk);
    endtask

    task automatic pulse_b();
        pin_b_in = 1'b1; repeat (4) @(negedge clk);
        pin_b_in = 1'b0; repeat (4) @(negedge clk);
    endtask

    task automatic t_reset();
        logic [15:0] v;
        for (int a = 0; a < 5; a++) begin
            rd(a[2:0], v);
            check("R1 reg zero", v, 0);
        end
        check("R1 irq", {irq_a, irq_b}, 0);
        check("R1 pin", {pin_a_out, pin_a_oe}, 0);
    endtask

    task automatic t_regs();
        logic [15:0] v;
        bus_wr(3'd1, 16'hA5C3); rd(3'd1, v); check("R2 reg A", v, 16'hA5C3);
        bus_wr(3'd2, 16'h1234); rd(3'd2, v); check("R2 reg B", v, 16'h1234);
        bus_wr(3'd0, 16'h00FF); rd(3'd0, v); check("R2 counter", v, 16'h00FF);
        bus_wr(3'd3, 16'h0030); rd(3'd3, v); check("R2 ctrl", v, 16'h0030);
        bus_wr(3'd3, 16'h0000);
    endtask

    task automatic t_event();
        logic [15:0] v;
        bus_wr(3'd3, 16'h0012);          // rising event mode, enable A
        bus_wr(3'd1, 16'd2);
        bus_wr(3'd0, 16'd1);
        ticks(5); rd(3'd0, v); check("R8 tick ignored", v, 1);
        pulse_a(); rd(3'd0, v); check("R8 rise step", v, 0);
        pulse_a(); rd(3'd0, v); check("R8 reload A", v, 2);
        rd(3'd4, v); check("R8 pend A", v, 1);
        check("R7 irq_a enabled", irq_a, 1);
        pin_a_in = 1'b1; repeat (20) @(negedge clk);
        rd(3'd0, v); check("R12 held high once", v, 1);
        pin_a_in = 1'b0; repeat (4) @(negedge clk);
        rd(3'd0, v); check("R8 fall ignored in rise mode", v, 1);
        pulse_b(); rd(3'd4, v); check("R9 pend B", v, 3);
        rd(3'd0, v); check("R9 counter unchanged", v, 1);
        check("R7 irq_b disabled", irq_b, 0);
        bus_wr(3'd4, 16'h0003); rd(3'd4, v); check("R11 w1c", v, 0);
        check("R7 irq_a cleared", irq_a, 0);
        bus_wr(3'd3, 16'h0003);          // falling event mode
        pin_a_in = 1'b1; repeat (4) @(negedge clk);
        rd(3'd0, v); check("R8 rise ignored in fall mode", v, 1);
        pin_a_in = 1'b0; repeat (4) @(negedge clk);
        rd(3'd0, v); check("R8 fall step", v, 0);
    endtask

    task automatic t_capture();
        logic [15:0] v;
        bus_wr(3'd3, 16'h0004);
        bus_wr(3'd0, 16'd100);
        ticks(10); rd(3'd0, v); check("R10 free run", v, 90);
        pulse_a(); rd(3'd1, v); check("R10 capture A", v, 90);
        rd(3'd4, v); check("R10 pend A", v, 1);
        ticks(5);
        pulse_b(); rd(3'd2, v); check("R10 capture B", v, 85);
        rd(3'd4, v); check("R10 pend both", v, 3);
        ticks(3);
        // edge on B takes effect two clocks after the pin change; clear lands there too
        pin_b_in = 1'b1;
        @(negedge clk);
        @(negedge clk);
        bus_wr(3'd4, 16'h0002);
        rd(3'd4, v); check("R11 set wins over clear", v[1], 1);
        rd(3'd2, v); check("R10 capture at collision", v, 82);
        repeat (4) @(negedge clk);
        pin_b_in = 1'b0; repeat (4) @(negedge clk);
        bus_wr(3'd4, 16'h0002);
        rd(3'd4, v); check("R11 plain clear", v, 1);
        bus_wr(3'd0, 16'd0);
        ticks(1); rd(3'd0, v); check("R10 wrap", v, 16'hFFFF);
        bus_wr(3'd4, 16'h0003);
    endtask

    task automatic t_pwm();
        logic [15:0] v;
        bus_wr(3'd0, 16'd2);
        bus_wr(3'd1, 16'd3);
        bus_wr(3'd2, 16'd5);
        bus_wr(3'd3, 16'h0039);          // PWM, toggle, enable A and B
        check("R5 oe in PWM", {pin_a_oe, pin_a_out}, 2'b10);
        ticks(2); rd(3'd0, v); check("R3 decrement", v, 0);
        ticks(1); rd(3'd0, v); check("R4 first reload A", v, 3);
        rd(3'd4, v); check("R6 pend A", v, 1);
        check("R5 toggle high", pin_a_out, 1);
        check("R7 irq_a", {irq_a, irq_b}, 2'b10);
        repeat (6) @(negedge clk);
        rd(3'd0, v); check("R3 hold no tick", v, 3);
        ticks(4); rd(3'd0, v); check("R4 second reload B", v, 5);
        rd(3'd4, v); check("R6 pend B", v, 3);
        check("R5 toggle low", pin_a_out, 0);
        check("R7 irq_b", irq_b, 1);
        ticks(6); rd(3'd0, v); check("R4 third reload A", v, 3);
        check("R5 toggle high again", pin_a_out, 1);
        bus_wr(3'd3, 16'h0000);
        check("R5 oe off idle", {pin_a_oe, pin_a_out}, 0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_regs();
        t_event();
        t_capture();
        t_pwm();
        done = 1;
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog: actual hung expected done");
            $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
            $finish;
        end
    end

endmodule